// File: doc/BRIEF.md
# Programmable clock output generator

The block drives up to eight programmable clock outputs. Each output picks one of several source clocks and divides it by a programmable factor. Every output has its own control register, written over a plain write-strobe register port, and one shared status register shows, per output, whether that output is running on its current settings. The source clocks are not routed through the block. Each source is presented as a one-cycle strobe on `src_tick` that marks every rising edge of that source, synchronous to `clk`, and all counting and switching happen in the `clk` domain.

Two field layouts are build-time choices. The narrow layout has a 2-bit source field and can add an extra master-select bit that reaches source 4. The wide layout has a 3-bit source field and moves the prescaler up. A second build-time choice sets the prescaler meaning: either a power-of-two shift or a direct divide by (code + 1). A write that changes an output's settings clears that output's ready flag. The output then finishes its current period, stays low, and restarts on the new settings with the first strobe of the new source. Ready sets again on that strobe.

Each output runs a small state machine with four states. `CH_START` waits after reset for the first strobe of the selected source. `CH_RUN` is normal operation with ready set. `CH_DRAIN` lets the old setting finish its current period. `CH_SYNC` holds the output low until the new source strobes. The transitions are:
- `CH_START` to `CH_RUN` on a source strobe when no write arrives in the same cycle. A write in `CH_START` loads the new setting directly and stays in `CH_START`.
- `CH_RUN` to `CH_DRAIN` on a write that changes the setting.
- `CH_DRAIN` to `CH_SYNC` on the strobe that ends the old period.
- `CH_SYNC` to `CH_RUN` on the first strobe of the new source.
- `CH_SYNC` back to `CH_DRAIN` on a write that changes the setting.

Top module: `pclk_gen`

## Requirements
- R1: After reset every control register reads 0, which means source 0 and divide-by-1. The status register reads 0 until the selected source of an output has strobed.
- R2: In the narrow layout, address i (i < NUM_OUT) holds output i's control register.
  - Bits 1:0 are the source field and bits 4:2 are the prescaler code.
  - Bit 8 is the master-select bit.
  - All other bits are ignored on write and read back as 0.
- R3: The status register is at address 8. The ready flag of output i is bit i+8, and every other bit reads 0. After reset, each output sets its ready flag on the first strobe of its selected source.
- R4: In power-of-two mode with code p, the output period is 2^p source periods. The output is high for 2^(p-1) of them, starting at a source strobe.
- R5: With a divide factor of 1, the output repeats every source strobe as a pulse one `clk` cycle wide.
- R6: In power-of-two mode, prescaler code 7 is rejected. The whole write is dropped and the register keeps its old value.
- R7: In the narrow layout with the master option, bit 8 set with a zero source field selects source 4. Bit 8 set with a nonzero source field is rejected and leaves the register unchanged.
- R8: A write that changes an output's setting clears its ready flag in the next cycle. A write of the value already held leaves the ready flag set. Ready sets again once the output runs on the new setting.
- R9: On a change, the output completes its current period and stays low until the first strobe of the new source. It then rises together with its ready flag. No high pulse is shorter than the shorter of the old and new high times.
- R10: In the wide layout with direct prescaling:
  - Bits 2:0 are the source field and bits 6:4 are the prescaler code.
  - The divide factor is N = code + 1, and code 7 (N = 8) is legal.
  - The output is high for floor(N/2) source periods of every N.
- R11: In the wide layout, a source index of NUM_SRC or more is rejected and the register keeps its old value. Any index below NUM_SRC is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all strobes and register accesses are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NUM_SRC | One-cycle strobe per rising edge of each source clock |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 4 | Register address: 0..NUM_OUT-1 control, 8 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pck | output | NUM_OUT | Programmable clock outputs |

## Verification
Register reads are combinational, so control and status values are sampled in the same cycle that `addr` is set. The one exception is that a ready flag cleared by a write shows on the first read after the edge that took the write. Clock outputs react to source strobes with one register of delay. For that reason, each expected period and high time is counted in `clk` cycles as a whole number of source periods. Each measurement skips two output rising edges after the settings have settled and then measures the next complete period. The glitch check tracks every high run of an output across a whole switchover window rather than at one fixed cycle.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [1:0] {
        CH_START,
        CH_RUN,
        CH_DRAIN,
        CH_SYNC
    } ch_state_t;

    typedef struct packed {
        logic [2:0] src;
        logic [2:0] pres;
    } ch_cfg_t;

    localparam int MCK_BIT  = 8;
    localparam int RDY_BASE = 8;
    localparam int CNT_W    = 7;

    // Division factor for a prescaler code: direct (code+1) or power of two.
    function automatic logic [CNT_W-1:0] div_of(input logic [2:0] pres, input logic direct);
        if (direct)
            return CNT_W'(pres) + CNT_W'(1);
        else
            return CNT_W'(1) << pres;
    endfunction

endpackage

// File: rtl/pclk_regdec.sv
module pclk_regdec
    import pclk_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter bit WIDE    = 1'b0,
    parameter bit HAS_MCK = 1'b1,
    parameter bit DIRECT  = 1'b0
) (
    input  logic [31:0] wdata,
    output logic        ok,
    output ch_cfg_t     cfg,
    output logic [31:0] word
);
    localparam int PRES_LSB = WIDE ? 4 : 2;
    localparam int SRC_W    = WIDE ? 3 : 2;
    localparam bit MCK_ON   = !WIDE && HAS_MCK;

    logic [2:0] field;
    logic [2:0] pres;
    logic       mck;
    logic       src_ok;
    logic       pres_ok;
    logic       unused_bits;

    always_comb begin
        pres    = wdata[PRES_LSB +: 3];
        field   = 3'(wdata[SRC_W-1:0]);
        mck     = MCK_ON ? wdata[MCK_BIT] : 1'b0;
        src_ok  = mck ? (field == 3'd0) : (32'(field) < NUM_SRC);
        pres_ok = DIRECT || (pres != 3'd7);
        ok      = src_ok && pres_ok;
        cfg.pres = pres;
        cfg.src  = mck ? 3'd4 : field;
        word = '0;
        word[PRES_LSB +: 3] = pres;
        word[SRC_W-1:0]     = field[SRC_W-1:0];
        if (mck)
            word[MCK_BIT] = 1'b1;
    end

    assign unused_bits = ^wdata;

endmodule

// File: rtl/pclk_chan.sv
module pclk_chan
    import pclk_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter bit DIRECT  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  ch_cfg_t            new_cfg,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               pck,
    output logic               ready
);
    ch_state_t state_q, state_d;
    ch_cfg_t   act_q, pend_q, sw_cfg;

    logic [CNT_W-1:0] cnt_q, cnt_nx, cnt_adv;
    logic [CNT_W-1:0] n_act, n_new, n_sw, half;
    logic [7:0]       tick_pad;
    logic             tick_act, at_end, change, out_q, out_adv;

    always_comb begin
        tick_pad = 8'(src_tick);
        tick_act = tick_pad[act_q.src];
        n_act    = div_of(act_q.pres, DIRECT);
        n_new    = div_of(new_cfg.pres, DIRECT);
        sw_cfg   = we ? new_cfg : pend_q;
        n_sw     = div_of(sw_cfg.pres, DIRECT);
        half     = n_act >> 1;
        at_end   = cnt_q >= (n_act - CNT_W'(1));
        cnt_nx   = at_end ? '0 : cnt_q + CNT_W'(1);
        cnt_adv  = tick_act ? cnt_nx : cnt_q;
        if (n_act == CNT_W'(1))
            out_adv = tick_act;
        else if (tick_act)
            out_adv = cnt_nx < half;
        else
            out_adv = out_q;
        change   = we && (new_cfg != act_q);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_START: if (!we && tick_act) state_d = CH_RUN;
            CH_RUN:   if (change) state_d = CH_DRAIN;
            CH_DRAIN: if (tick_act && at_end) state_d = CH_SYNC;
            CH_SYNC: begin
                if (change)
                    state_d = CH_DRAIN;
                else if (tick_act)
                    state_d = CH_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= CH_START;
        else
            state_q <= state_d;
    end

    // divider datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            pend_q <= '0;
            cnt_q  <= '0;
            out_q  <= 1'b0;
        end else begin
            unique case (state_q)
                CH_START: begin
                    if (we) begin
                        act_q  <= new_cfg;
                        pend_q <= new_cfg;
                        cnt_q  <= n_new - CNT_W'(1);
                        out_q  <= 1'b0;
                    end else begin
                        cnt_q  <= cnt_adv;
                        out_q  <= out_adv;
                    end
                end
                CH_RUN, CH_SYNC: begin
                    if (change)
                        pend_q <= new_cfg;
                    cnt_q <= cnt_adv;
                    out_q <= out_adv;
                end
                CH_DRAIN: begin
                    if (we)
                        pend_q <= new_cfg;
                    if (tick_act && at_end) begin
                        act_q <= sw_cfg;
                        cnt_q <= n_sw - CNT_W'(1);
                        out_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_adv;
                        out_q <= out_adv;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ready = (state_q == CH_RUN);
        pck   = out_q;
    end

endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
    import pclk_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int NUM_SRC = 5,
    parameter bit WIDE    = 1'b0,
    parameter bit HAS_MCK = 1'b1,
    parameter bit DIRECT  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_en,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [NUM_OUT-1:0] pck
);
    localparam int MAX_OUT   = 8;
    localparam int STAT_ADDR = 8;

    logic               dec_ok;
    ch_cfg_t            dec_cfg;
    logic [31:0]        dec_word;
    logic               addr_is_ctrl;
    logic               wr_ok;
    logic [31:0]        ctrl_q [MAX_OUT];
    logic [MAX_OUT*32-1:0] ctrl_flat;
    logic [31:0]        cur_word;
    logic [31:0]        status;
    logic [NUM_OUT-1:0] ready;

    pclk_regdec #(
        .NUM_SRC(NUM_SRC),
        .WIDE   (WIDE),
        .HAS_MCK(HAS_MCK),
        .DIRECT (DIRECT)
    ) u_dec (
        .wdata(wdata),
        .ok   (dec_ok),
        .cfg  (dec_cfg),
        .word (dec_word)
    );

    always_comb begin
        addr_is_ctrl = !addr[3] && (32'(addr[2:0]) < NUM_OUT);
        wr_ok        = wr_en && dec_ok && addr_is_ctrl;
    end

    for (genvar g = 0; g < MAX_OUT; g++) begin : g_reg
        if (g < NUM_OUT) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ctrl_q[g] <= '0;
                else if (wr_ok && addr[2:0] == 3'(g))
                    ctrl_q[g] <= dec_word;
            end
        end else begin : g_none
            assign ctrl_q[g] = '0;
        end
        assign ctrl_flat[g*32 +: 32] = ctrl_q[g];
    end

    for (genvar c = 0; c < NUM_OUT; c++) begin : g_ch
        pclk_chan #(
            .NUM_SRC(NUM_SRC),
            .DIRECT (DIRECT)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_ok && addr[2:0] == 3'(c)),
            .new_cfg (dec_cfg),
            .src_tick(src_tick),
            .pck     (pck[c]),
            .ready   (ready[c])
        );
    end

    always_comb begin
        status = '0;
        for (int i = 0; i < NUM_OUT; i++)
            status[RDY_BASE + i] = ready[i];
        cur_word = ctrl_q[addr[2:0]];
        if (addr_is_ctrl)
            rdata = cur_word;
        else if (addr == 4'(STAT_ADDR))
            rdata = status;
        else
            rdata = '0;
    end

endmodule

// File: rtl/pclk_chk.sv
module pclk_chk #(
    parameter int NUM_OUT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [3:0]         addr,
    input logic               wr_ok,
    input logic [31:0]        dec_word,
    input logic [31:0]        cur_word,
    input logic [255:0]       ctrl_flat,
    input logic [NUM_OUT-1:0] ready,
    input logic [NUM_OUT-1:0] pck,
    input logic [31:0]        rdata
);
    localparam logic [31:0] RDY_MASK = 32'(((1 << NUM_OUT) - 1) << 8);

    logic [7:0] ready_pad;
    assign ready_pad = 8'(ready);

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> $stable(ctrl_flat)); // R6

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && dec_word != cur_word) |=> !ready_pad[$past(addr[2:0])]); // R8

    AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'd8) |-> ((rdata & ~RDY_MASK) == 32'd0)); // R3

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_edge
        AST_RESUME_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ready[i]) |-> $rose(pck[i])); // R9
    end

endmodule

bind pclk_gen pclk_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_ok    (wr_ok),
    .dec_word (dec_word),
    .cur_word (cur_word),
    .ctrl_flat(ctrl_flat),
    .ready    (ready),
    .pck      (pck),
    .rdata    (rdata)
);

// File: tb/sim_pclk_gen.sv
module sim_pclk_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    localparam int PER [5] = '{2, 3, 4, 5, 7};

    logic       tick_en = 1'b0;
    logic [4:0] src_tick = '0;
    int         tcnt [5];

    logic        wr_en0 = 1'b0, wr_en1 = 1'b0;
    logic [3:0]  addr0 = '0, addr1 = '0;
    logic [31:0] wdata0 = '0, wdata1 = '0;
    logic [31:0] rdata0, rdata1;
    logic [7:0]  pck0;
    logic [1:0]  pck1;

    int checks = 0;
    int failures = 0;

    pclk_gen #(.NUM_OUT(8), .NUM_SRC(5), .WIDE(1'b0), .HAS_MCK(1'b1), .DIRECT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en0),
        .addr(addr0), .wdata(wdata0), .rdata(rdata0), .pck(pck0)
    );

    pclk_gen #(.NUM_OUT(2), .NUM_SRC(5), .WIDE(1'b1), .HAS_MCK(1'b0), .DIRECT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en1),
        .addr(addr1), .wdata(wdata1), .rdata(rdata1), .pck(pck1)
    );

    // source strobes, one per source period
    always @(negedge clk) begin
        for (int s = 0; s < 5; s++) begin
            if (!tick_en) begin
                src_tick[s] <= 1'b0;
                tcnt[s] <= 0;
            end else if (tcnt[s] == PER[s] - 1) begin
                src_tick[s] <= 1'b1;
                tcnt[s] <= 0;
            end else begin
                src_tick[s] <= 1'b0;
                tcnt[s] <= tcnt[s] + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int inst, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (inst == 0) begin wr_en0 = 1'b1; addr0 = a; wdata0 = d; end
        else begin wr_en1 = 1'b1; addr1 = a; wdata1 = d; end
        @(negedge clk);
        wr_en0 = 1'b0;
        wr_en1 = 1'b0;
    endtask

    task automatic rd(input int inst, input logic [3:0] a, output logic [31:0] d);
        if (inst == 0) addr0 = a; else addr1 = a;
        #1;
        d = (inst == 0) ? rdata0 : rdata1;
    endtask

    function automatic logic pbit(input int inst, input int ch);
        return (inst == 0) ? pck0[ch] : pck1[ch];
    endfunction

    // scoreboard
    typedef struct {
        int    inst;
        int    ch;
        int    period;
        int    high;
        string tag;
    } exp_t;

    exp_t exp_q [$];
    int   done_cnt = 0;

    task automatic expect_clk(input int inst, input int ch, input int period, input int high, input string tag);
        exp_t it;
        int n;
        it.inst = inst; it.ch = ch; it.period = period; it.high = high; it.tag = tag;
        n = done_cnt;
        exp_q.push_back(it);
        wait (done_cnt > n);
    endtask

    initial begin : monitor
        forever begin
            exp_t it;
            int rises, hi, per;
            logic prev, cur;
            wait (exp_q.size() > 0);
            it = exp_q[0];
            rises = 0; hi = 0; per = 0;
            prev = pbit(it.inst, it.ch);
            while (rises < 3) begin
                @(negedge clk);
                cur = pbit(it.inst, it.ch);
                if (cur && !prev) rises++;
                if (rises == 2) begin
                    per++;
                    if (cur) hi++;
                end
                prev = cur;
            end
            chk({it.tag, " period"}, per, it.period);
            chk({it.tag, " high"}, hi, it.high);
            void'(exp_q.pop_front());
            done_cnt++;
        end
    end

    // high-run tracker on u0 output 0 for the switchover window
    logic win_en = 1'b0;
    int   hi_run = 0;
    int   win_min = 999;
    always @(negedge clk) begin
        if (pck0[0]) begin
            hi_run <= hi_run + 1;
        end else begin
            if (hi_run > 0 && win_en && hi_run < win_min)
                win_min <= hi_run;
            hi_run <= 0;
        end
    end

    initial begin : watchdog
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 4'd0, d); chk("R1 u0 ctrl0", d, 32'h0);
        rd(0, 4'd7, d); chk("R1 u0 ctrl7", d, 32'h0);
        rd(0, 4'd8, d); chk("R1 u0 status", d, 32'h0);
        rd(1, 4'd8, d); chk("R1 u1 status", d, 32'h0);

        // R3 ready at bit id+8 once sources run
        tick_en = 1'b1;
        repeat (20) @(negedge clk);
        rd(0, 4'd8, d); chk("R3 u0 status", d, 32'h0000_FF00);
        rd(1, 4'd8, d); chk("R3 u1 status", d, 32'h0000_0300);

        // R5 pass-through on default setting (source 0, period 2)
        expect_clk(0, 3, 2, 1, "R5 u0 ch3");

        // R2 field positions, R8 ready drops on change, R4 power-of-two
        wr(0, 4'd0, 32'h0000_0009);
        rd(0, 4'd8, d); chk("R8 ready cleared", d & 32'h100, 32'h0);
        rd(0, 4'd0, d); chk("R2 ctrl0 readback", d, 32'h9);
        expect_clk(0, 0, 12, 6, "R4 src1 p2");
        rd(0, 4'd8, d); chk("R8 ready restored", d & 32'h100, 32'h100);
        wr(0, 4'd0, 32'h0000_0009);
        rd(0, 4'd8, d); chk("R8 same write keeps ready", d & 32'h100, 32'h100);

        // R6 code 7 rejected in power-of-two mode
        wr(0, 4'd1, 32'h0000_001E);
        rd(0, 4'd1, d); chk("R6 ctrl1 unchanged", d, 32'h0);
        rd(0, 4'd8, d); chk("R6 status unchanged", d, 32'h0000_FF00);

        // R2 ignored bits
        wr(0, 4'd4, 32'h0000_00E1);
        rd(0, 4'd4, d); chk("R2 spare bits dropped", d, 32'h1);

        // R7 master select
        wr(0, 4'd2, 32'h0000_0104);
        rd(0, 4'd2, d); chk("R7 ctrl2 readback", d, 32'h104);
        expect_clk(0, 2, 14, 7, "R7 master p1");
        wr(0, 4'd2, 32'h0000_0101);
        rd(0, 4'd2, d); chk("R7 bad master write held", d, 32'h104);

        // R9 glitch-free switchover, then R4 on new setting
        win_en = 1'b1;
        wr(0, 4'd0, 32'h0000_0004);
        repeat (80) @(negedge clk);
        win_en = 1'b0;
        chk("R9 min high run", (win_min >= 2) ? 32'd1 : 32'd0, 32'd1);
        expect_clk(0, 0, 4, 2, "R4 src0 p1");

        // R10 wide layout, direct divide
        wr(1, 4'd0, 32'h0000_0020);
        rd(1, 4'd0, d); chk("R10 u1 ctrl0 readback", d, 32'h20);
        expect_clk(1, 0, 6, 2, "R10 div3");
        wr(1, 4'd1, 32'h0000_0073);
        rd(1, 4'd1, d); chk("R10 u1 code7 accepted", d, 32'h73);
        expect_clk(1, 1, 40, 20, "R10 div8");

        // R11 source range in wide layout
        wr(1, 4'd0, 32'h0000_0005);
        rd(1, 4'd0, d); chk("R11 src5 rejected", d, 32'h20);
        wr(1, 4'd0, 32'h0000_0004);
        rd(1, 4'd0, d); chk("R11 src4 accepted", d, 32'h4);
        expect_clk(1, 0, 7, 1, "R11 src4 div1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule